// File: doc/BRIEF.md
# Flag-Setting 16-Bit ALU

This block is the arithmetic and logic unit of a small 16-bit processor core. It takes two operands, a 4-bit operation select and the carry flag held in its own flag register. It produces a result, a set of four candidate flags (zero, negative, carry, overflow) and a write mask that names which of those flags the operation is allowed to change. The result and the mask are combinational. The flags themselves sit in a small register inside the block.

A valid strobe commits an operation. On that clock edge only the masked flag bits take their new values, and every other bit keeps its old one. A separate add-immediate mode sends a sign-extended 6-bit immediate through the same adder in place of the second operand. Logic operations, single-bit shifts, rotates through carry and add/subtract with or without carry each touch a different subset of the flags. Later conditional branches read the flags, so a wrong subset is a real fault.

Top module: `flag_alu16`

## Requirements
- R1: With imm_mode low, op_sel 0 gives A AND B, 1 gives A OR B, 6 gives A XOR B and 7 gives NOT A. The flag_wmask output uses bit order 0 = zero, 1 = negative, 2 = carry, 3 = overflow.
- R2: Op codes 0, 1, 6, 7, 10 and 11 assert flag_wmask = 4'b0011, so only zero and negative are written.
- R3: op_sel 2 gives A shifted left by one with a 0 shifted in, and op_sel 3 gives a logical right shift by one. The carry candidate is the bit shifted out (A[15] or A[0]), and flag_wmask = 4'b0111.
- R4: op_sel 4 gives A+B and op_sel 8 gives A+B+carry_flag. Carry is the unsigned carry out of bit 15, and overflow is set when the two's-complement sum is out of range.
- R5: op_sel 5 gives A−B and op_sel 9 gives A−B−carry_flag. Carry is set when a borrow occurred (unsigned A < B + borrow_in), and overflow is set when the signed difference is out of range.
- R6: op_sel 10 gives {A[14:0], carry_flag} and op_sel 11 gives {carry_flag, A[15:1]}, where carry_flag is the value held before the operation.
- R7: With imm_mode high, op_sel is ignored and the result is A plus imm_val sign-extended from 6 bits, with flags as for op 4.
- R8: Op codes 12 to 15 (imm_mode low) return 0 and assert flag_wmask = 0.
- R9: Each operation that writes flags and arithmetic ops (4, 5, 8, 9 and add-immediate) write flag_wmask = 4'b1111. Zero is set when all 16 result bits are 0, and negative equals result bit 15.
- R10: On a clock edge with valid high, each flags bit whose mask bit is set takes its candidate value and the other bits hold. With valid low, all flags hold. The flags output uses the same bit order as flag_wmask.
- R11: A synchronous active-low reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Commit the current operation's flags on this edge |
| op_sel | input | 4 | Operation code |
| imm_mode | input | 1 | Select add-immediate in place of op_sel |
| imm_val | input | 6 | Signed immediate for add-immediate |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Combinational result |
| flag_wmask | output | 4 | Flags the current operation writes |
| flags | output | 4 | Registered flags {V,C,N,Z} |

## Verification
The only state in this block is the flag register, and it shows at the flags port one edge after a committed operation. The carry bit also feeds the result combinationally through adc, sbc and the rotates. A mask bit that is wrong or set when it should not be therefore shows up as a flag that changed or failed to change on the very next edge. A wrongly held carry shows up in the very next carry-consuming result. The bench chains random operations so that every stale or corrupted flag propagates into later results and flag comparisons.

// File: rtl/flag_alu16_pkg.sv
// Package: shared op codes and flag bit positions for the flag-setting ALU.
// Assumes a 4-bit operation select; codes 12..15 are unused.
package flag_alu16_pkg;
    localparam int unsigned NFLAGS = 4;
    localparam int unsigned FZ = 0;
    localparam int unsigned FN = 1;
    localparam int unsigned FC = 2;
    localparam int unsigned FV = 3;

    localparam logic [3:0] OP_AND = 4'd0;
    localparam logic [3:0] OP_OR  = 4'd1;
    localparam logic [3:0] OP_SHL = 4'd2;
    localparam logic [3:0] OP_SHR = 4'd3;
    localparam logic [3:0] OP_ADD = 4'd4;
    localparam logic [3:0] OP_SUB = 4'd5;
    localparam logic [3:0] OP_XOR = 4'd6;
    localparam logic [3:0] OP_NOT = 4'd7;
    localparam logic [3:0] OP_ADC = 4'd8;
    localparam logic [3:0] OP_SBC = 4'd9;
    localparam logic [3:0] OP_ROL = 4'd10;
    localparam logic [3:0] OP_ROR = 4'd11;

    localparam logic [NFLAGS-1:0] MASK_NONE = 4'b0000;
    localparam logic [NFLAGS-1:0] MASK_NZ   = 4'b0011;
    localparam logic [NFLAGS-1:0] MASK_CNZ  = 4'b0111;
    localparam logic [NFLAGS-1:0] MASK_ALL  = 4'b1111;
endpackage

// File: rtl/flag_alu16_addsub.sv
// Module: shared adder/subtractor. It computes a + b + cin, or a - b - borrow, in one carry chain.
// Assumes: the carry output is "borrow occurred" when sub is set.
module flag_alu16_addsub #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         use_carry,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_flag,
    output logic         ovf_flag
);
    logic [W-1:0] b_eff;
    logic         cin;
    logic         cout;

    // Invert b for subtraction and select the carry-in / inverted borrow.
    always_comb begin
        b_eff = sub ? ~b : b;
        if (use_carry) cin = sub ? ~carry_in : carry_in;
        else           cin = sub;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        carry_flag  = sub ? ~cout : cout;
        ovf_flag    = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/flag_alu16_bitops.sv
// Module: bitwise ops, single-bit shifts and rotates through carry.
// Assumes: op is one of the non-arithmetic codes; other codes give zero.
module flag_alu16_bitops
    import flag_alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output logic         shift_carry
);
    // Select the bitwise, shift or rotate result and the bit shifted out.
    always_comb begin
        shift_carry = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_SHL:  begin res = {a[W-2:0], 1'b0}; shift_carry = a[W-1]; end
            OP_SHR:  begin res = {1'b0, a[W-1:1]}; shift_carry = a[0];   end
            OP_ROL:  res = {a[W-2:0], carry_in};
            OP_ROR:  res = {carry_in, a[W-1:1]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu16_flagreg.sv
// Module: four-bit flag register with per-bit write mask.
// Assumes: synchronous active-low reset; mask bit order Z,N,C,V from bit 0.
module flag_alu16_flagreg
    import flag_alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [NFLAGS-1:0] wmask,
    input  logic [NFLAGS-1:0] new_flags,
    output logic [NFLAGS-1:0] flags_q
);
    // Merge masked candidate bits into the held flags on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (valid) flags_q <= (flags_q & ~wmask) | (new_flags & wmask);
    end

    // R10
    flags_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(flags_q));

    // R10
    carry_unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wmask[FC]) |=> $stable(flags_q[FC]));

    // R10
    ovf_unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wmask[FV]) |=> $stable(flags_q[FV]));
endmodule

// File: rtl/flag_alu16.sv
// Module: top-level flag-setting ALU. It decodes the op, muxes the units, forms the
// candidate flags and write mask, and holds the flags.
// Assumes: result and mask are combinational; flags change only on valid edges.
module flag_alu16
    import flag_alu16_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned IMM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [3:0]        op_sel,
    input  logic              imm_mode,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic [W-1:0]      result,
    output logic [NFLAGS-1:0] flag_wmask,
    output logic [NFLAGS-1:0] flags
);
    localparam int unsigned EXT_W = W - IMM_W;

    logic [W-1:0] imm_ext;
    logic [W-1:0] as_b;
    logic         as_sub;
    logic         as_use_c;
    logic [W-1:0] as_sum;
    logic         as_carry;
    logic         as_ovf;
    logic [W-1:0] bo_res;
    logic         bo_carry;
    logic [NFLAGS-1:0] cand;
    logic         is_arith;

    // Sign-extend the immediate and pick adder controls from mode and op.
    always_comb begin
        imm_ext  = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        as_b     = imm_mode ? imm_ext : opnd_b;
        as_sub   = !imm_mode && (op_sel == OP_SUB || op_sel == OP_SBC);
        as_use_c = !imm_mode && (op_sel == OP_ADC || op_sel == OP_SBC);
        is_arith = imm_mode || op_sel == OP_ADD || op_sel == OP_SUB ||
                   op_sel == OP_ADC || op_sel == OP_SBC;
    end

    flag_alu16_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(as_b), .sub(as_sub), .use_carry(as_use_c),
        .carry_in(flags[FC]), .sum(as_sum), .carry_flag(as_carry), .ovf_flag(as_ovf)
    );

    flag_alu16_bitops #(.W(W)) u_bitops (
        .op(op_sel), .a(opnd_a), .b(opnd_b), .carry_in(flags[FC]),
        .res(bo_res), .shift_carry(bo_carry)
    );

    // Choose the result and write mask for the current operation.
    always_comb begin
        if (is_arith) begin
            result     = as_sum;
            flag_wmask = MASK_ALL;
        end else begin
            result = bo_res;
            unique case (op_sel)
                OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ROL, OP_ROR: flag_wmask = MASK_NZ;
                OP_SHL, OP_SHR:                               flag_wmask = MASK_CNZ;
                default:                                      flag_wmask = MASK_NONE;
            endcase
        end
    end

    // Form candidate flag values from the selected result.
    always_comb begin
        cand     = '0;
        cand[FZ] = (result == '0);
        cand[FN] = result[W-1];
        cand[FC] = is_arith ? as_carry : bo_carry;
        cand[FV] = is_arith ? as_ovf : 1'b0;
    end

    flag_alu16_flagreg u_flagreg (
        .clk(clk), .rst_n(rst_n), .valid(valid),
        .wmask(flag_wmask), .new_flags(cand), .flags_q(flags)
    );

    // R8
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !imm_mode && op_sel >= 4'd12) |=> $stable(flags));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && flag_wmask[FZ]) |=> (flags[FZ] == ($past(result) == '0)));

    // R9
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && flag_wmask[FN]) |=> (flags[FN] == $past(result[W-1])));

    // R6
    rol_carry_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode && op_sel == OP_ROL) |-> (result[0] == flags[FC]));
endmodule

// File: tb/flag_alu16_bench.sv
module flag_alu16_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        imm_mode = 1'b0;
    logic [5:0]  imm_val = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] result;
    logic [3:0]  flag_wmask;
    logic [3:0]  flags;

    int total = 0;
    int bad = 0;
    logic [3:0] mflags = '0;

    always #2 clk = ~clk;

    flag_alu16 u_flag_alu16 (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op_sel(op_sel),
        .imm_mode(imm_mode), .imm_val(imm_val), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .flag_wmask(flag_wmask), .flags(flags)
    );

    function automatic string tag_of(input logic im, input logic [3:0] o);
        if (im) return "R7";
        case (o)
            4'd0, 4'd1, 4'd6, 4'd7: return "R1";
            4'd2, 4'd3:             return "R3";
            4'd4, 4'd8:             return "R4";
            4'd5, 4'd9:             return "R5";
            4'd10, 4'd11:           return "R6";
            default:                return "R8";
        endcase
    endfunction

    // Reference model from the requirements; flags {V,C,N,Z}.
    task automatic model(input logic im, input logic [3:0] o, input logic [15:0] a,
                         input logic [15:0] b, input logic [5:0] i, input logic c,
                         output logic [15:0] r, output logic [3:0] nf, output logic [3:0] m);
        int ua, ub, sa, sb, t, st, cin;
        logic cy, ov;
        ua = int'(a); ub = int'(b); sa = int'($signed(a)); sb = int'($signed(b));
        cy = 1'b0; ov = 1'b0; r = '0; m = 4'b0000;
        if (im) begin
            sb = int'($signed(i)); ub = sb & 16'hFFFF;
            t = ua + ub; st = sa + sb;
            r = t[15:0]; cy = t > 16'hFFFF; ov = st > 32767 || st < -32768; m = 4'b1111;
        end else case (o)
            4'd0: begin r = a & b; m = 4'b0011; end
            4'd1: begin r = a | b; m = 4'b0011; end
            4'd6: begin r = a ^ b; m = 4'b0011; end
            4'd7: begin r = ~a;    m = 4'b0011; end
            4'd2: begin r = a << 1; cy = a[15]; m = 4'b0111; end
            4'd3: begin r = a >> 1; cy = a[0];  m = 4'b0111; end
            4'd10: begin r = {a[14:0], c}; m = 4'b0011; end
            4'd11: begin r = {c, a[15:1]}; m = 4'b0011; end
            4'd4, 4'd8: begin
                cin = (o == 4'd8) ? int'(c) : 0;
                t = ua + ub + cin; st = sa + sb + cin;
                r = t[15:0]; cy = t > 16'hFFFF; ov = st > 32767 || st < -32768; m = 4'b1111;
            end
            4'd5, 4'd9: begin
                cin = (o == 4'd9) ? int'(c) : 0;
                t = ua - ub - cin; st = sa - sb - cin;
                r = t[15:0]; cy = t < 0; ov = st > 32767 || st < -32768; m = 4'b1111;
            end
            default: begin r = '0; m = 4'b0000; end
        endcase
        nf = {ov, cy, r[15], r == 16'h0000};
    endtask

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one operation, check result/mask, then check flags after the edge.
    task automatic step(input logic v, input logic im, input logic [3:0] o,
                        input logic [15:0] a, input logic [15:0] b, input logic [5:0] i);
        logic [15:0] er; logic [3:0] ef, em; string tg;
        @(negedge clk);
        valid = v; imm_mode = im; op_sel = o; opnd_a = a; opnd_b = b; imm_val = i;
        #1;
        model(im, o, a, b, i, mflags[2], er, ef, em);
        tg = tag_of(im, o);
        chk(tg, "result", result, er);
        chk((em == 4'b0011) ? "R2" : (em == 4'b1111 ? "R9" : tg), "wmask", {12'h0, flag_wmask}, {12'h0, em});
        if (v) mflags = (mflags & ~em) | (ef & em);
        @(posedge clk); #1;
        chk(v ? "R10" : "R10", v ? "flags after commit" : "flags idle hold", {12'h0, flags}, {12'h0, mflags});
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R11", "flags after reset", {12'h0, flags}, 16'h0000);

        // Directed corner cases.
        step(1, 0, 4'd4, 16'h7FFF, 16'h0001, 0);   // R4 signed overflow
        step(1, 0, 4'd4, 16'hFFFF, 16'h0001, 0);   // R4 carry, zero result
        step(1, 0, 4'd8, 16'h0001, 16'h0001, 0);   // R4 adc with carry set
        step(1, 0, 4'd5, 16'h0000, 16'h0001, 0);   // R5 borrow
        step(1, 0, 4'd9, 16'h0005, 16'h0002, 0);   // R5 sbc with borrow in
        step(1, 0, 4'd5, 16'h8000, 16'h0001, 0);   // R5 signed overflow
        step(1, 0, 4'd2, 16'h8001, 16'h0000, 0);   // R3 carry out of shl
        step(1, 0, 4'd10, 16'h4000, 16'h0000, 0);  // R6 rol with carry set
        step(1, 0, 4'd3, 16'h0003, 16'h0000, 0);   // R3 shr carry
        step(1, 0, 4'd11, 16'h0002, 16'h0000, 0);  // R6 ror carry into msb
        step(1, 0, 4'd13, 16'hFFFF, 16'hFFFF, 0);  // R8 unused code, flags hold
        step(0, 0, 4'd5, 16'h0000, 16'h0001, 0);   // R10 no strobe, no change
        step(1, 1, 4'd0, 16'h0010, 16'h1234, 6'b100000); // R7 imm -32
        step(1, 1, 4'd15, 16'h7FE1, 16'h0000, 6'b011111); // R7 imm +31 overflow
        step(1, 0, 4'd7, 16'h0000, 16'h0000, 0);   // R1 not
        step(1, 0, 4'd0, 16'hF0F0, 16'h0F0F, 0);   // R1 and to zero

        // Constrained random operations.
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra, rb; logic [3:0] ro; logic rv, ri;
            ro = 4'($urandom_range(0, 15));
            ri = ($urandom_range(0, 7) == 0);
            rv = ($urandom_range(0, 5) != 0);
            case ($urandom_range(0, 4))
                0: ra = 16'h0000;
                1: ra = 16'hFFFF;
                2: ra = 16'h8000 | 16'($urandom_range(0, 3));
                default: ra = 16'($urandom);
            endcase
            rb = ($urandom_range(0, 3) == 0) ? ra : 16'($urandom);
            step(rv, ri, ro, ra, rb, 6'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule